// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block is the control-port slave of an optical front-monitor receiver. A host talks to it over three wires: an active-high frame enable, a serial clock, and one shared data line. Each frame is sixteen serial clock rising edges long. The first byte is an address and the second byte is data. Both bytes are sent most significant bit first. Address bit 7 sets the direction: 1 means read, 0 means write. The slave answers only when address bits 6:4 fall inside the window chosen by a two-bit strap code. The strap therefore lets up to three devices share one bus.

The slave holds one control byte and three 8-bit gain steps, one for each wavelength channel. From these registers it drives three registered outputs to the analog side: a sleep flag, a channel code, and the gain step of the selected channel. The serial pins are sampled by the system clock through synchronizers. The data line is split into input, output and output-enable signals, and the pad is placed outside the block.

Top module: `tw_ctrl_slave`

## Requirements
- R1: A frame is the serial clock rising edges seen while frame_en is high. Edges 1 to 8 carry the address and edges 9 to 16 carry the data, each byte MSB first. A write takes effect on the 16th edge. Edges after the 16th are ignored.
- R2: Address bit 7 is the direction (1 = read, 0 = write). Address bits 6:4 must equal the window code of the strap: strap 00 gives window 0h (00h–0Fh), strap 01 gives window 1h (10h–1Fh), and strap 10 or 11 gives window 7h (70h–7Fh). Bits 3:0 are the register offset.
- R3: Offset 0 is the control byte. All 8 bits can be written and read back, and it resets to 00h.
- R4: Offsets 1, 2 and 3 hold the gain steps of channels A, B and C. All 8 bits can be written and read back, and each resets to FFh.
- R5: Offsets 4 to 15 hold nothing. A write to any of them changes no register, and a read of any of them returns 00h.
- R6: A frame whose address is outside the active window never raises sdio_oe, and if it is a write it changes no register.
- R7: On a read inside the window, sdio_oe rises after the 8th edge. Data bit 7 is shown first, and each later edge shifts out the next lower bit. sdio_oe falls after the 16th edge.
- R8: sdio_oe is low whenever frame_en is low, including in the same cycle that frame_en drops in the middle of a frame.
- R9: A frame that ends before its 16th edge writes nothing.
- R10: The outputs are registered. sleep is 0 only when control bits 7:6 are 11. chan_sel is 0 (channel A) when control bits 5:4 are 00 or 01, 1 (channel B) when they are 10, and 2 (channel C) when they are 11. gain_step equals the gain of the selected channel. After reset, sleep is 1, chan_sel is 0 and gain_step is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 2 | Window select code (00 low, 01 high, 10/11 open) |
| frame_en | input | 1 | Active-high frame enable from the host |
| ser_clk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data line as seen at the pad |
| sdio_out | output | 1 | Serial read data towards the pad |
| sdio_oe | output | 1 | Pad driver enable for sdio_out |
| sleep | output | 1 | 1 while the power field is not 11 |
| chan_sel | output | 2 | Selected wavelength channel code |
| gain_step | output | 8 | Gain step of the selected channel |

## Verification
The assertions assume a host that behaves well. The strap is held constant during a frame. Each serial clock level, and each data value around a rising edge, lasts longer than the synchronizer latency, so every edge is seen exactly once. frame_en also stays low for several system clocks between frames. The bench meets these assumptions by construction: it holds each serial clock level for six system clocks and changes data only while the serial clock is low. It changes the strap only between frames, with idle time around each frame.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;
  localparam int BYTE_W  = 8;
  localparam int OFS_W   = 4;
  localparam int WIN_W   = 3;
  localparam int NUM_CH  = 3;
  localparam int PWR_HI  = 7;
  localparam int SEL_HI  = 5;

  typedef enum logic [1:0] {
    CH_A = 2'd0,
    CH_B = 2'd1,
    CH_C = 2'd2
  } chan_e;

  function automatic logic [WIN_W-1:0] window_of(input logic [1:0] strap);
    case (strap)
      2'b00:   return 3'h0;
      2'b01:   return 3'h1;
      default: return 3'h7;
    endcase
  endfunction

  function automatic chan_e chan_of(input logic [1:0] sel);
    case (sel)
      2'b10:   return CH_B;
      2'b11:   return CH_C;
      default: return CH_A;
    endcase
  endfunction
endpackage

// File: rtl/tw_frame_rx.sv
module tw_frame_rx
  import tw_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_en,
  input  logic              ser_clk,
  input  logic              sdio_in,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-2:0] addr_cand,
  output logic              wr_stb,
  output logic [DATA_W-2:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              edge_pulse,
  output logic              sdio_out,
  output logic              sdio_oe
);
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] clk_sync, en_sync, din_sync;
  logic                   clk_s, en_s, din_s, sclk_prev;
  logic [CNT_W-1:0]       bit_cnt;
  logic [DATA_W-1:0]      shreg, addr_q, out_sh, next_sh;
  logic                   drive_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sync <= '0;
      en_sync  <= '0;
      din_sync <= '0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
      en_sync  <= {en_sync[SYNC_STAGES-2:0], frame_en};
      din_sync <= {din_sync[SYNC_STAGES-2:0], sdio_in};
    end
  end

  assign clk_s      = clk_sync[SYNC_STAGES-1];
  assign en_s       = en_sync[SYNC_STAGES-1];
  assign din_s      = din_sync[SYNC_STAGES-1];
  assign edge_pulse = clk_s & ~sclk_prev;
  assign next_sh    = {shreg[DATA_W-2:0], din_s};
  assign addr_cand  = next_sh[DATA_W-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      addr_q    <= '0;
      out_sh    <= '0;
      drive_q   <= 1'b0;
      wr_stb    <= 1'b0;
    end else begin
      sclk_prev <= clk_s;
      wr_stb    <= 1'b0;
      if (!en_s) begin
        bit_cnt <= '0;
        drive_q <= 1'b0;
      end else if (edge_pulse && bit_cnt != CNT_W'(FRAME_BITS)) begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= next_sh;
        if (bit_cnt == CNT_W'(DATA_W - 1)) begin
          addr_q <= next_sh;
          if (next_sh[DATA_W-1] && rd_hit) begin
            out_sh  <= rd_data;
            drive_q <= 1'b1;
          end
        end else if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
          drive_q <= 1'b0;
          wr_stb  <= ~addr_q[DATA_W-1];
        end else begin
          out_sh <= {out_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign wr_addr  = addr_q[DATA_W-2:0];
  assign wr_data  = shreg;
  assign sdio_out = out_sh[DATA_W-1];
  assign sdio_oe  = drive_q & frame_en;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
  import tw_ctrl_pkg::*;
#(
  parameter int              DATA_W   = BYTE_W,
  parameter int              CH_COUNT = NUM_CH,
  parameter logic [BYTE_W-1:0] GAIN_RST = 8'hFF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 strap,
  input  logic [DATA_W-2:0]          rd_addr,
  output logic                       rd_hit,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       wr_stb,
  input  logic [DATA_W-2:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          ctrl_q,
  output logic [CH_COUNT*DATA_W-1:0] gain_flat
);
  localparam int WIN_LO = OFS_W;
  localparam int WIN_HI = OFS_W + WIN_W - 1;

  logic [WIN_W-1:0] win;
  logic             wr_hit;
  logic [OFS_W-1:0] rd_ofs, wr_ofs;

  assign win    = window_of(strap);
  assign rd_hit = (rd_addr[WIN_HI:WIN_LO] == win);
  assign wr_hit = (wr_addr[WIN_HI:WIN_LO] == win);
  assign rd_ofs = rd_addr[OFS_W-1:0];
  assign wr_ofs = wr_addr[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_stb && wr_hit && wr_ofs == '0) ctrl_q <= wr_data;
  end

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_gain
    always_ff @(posedge clk) begin
      if (rst) gain_flat[g*DATA_W +: DATA_W] <= DATA_W'(GAIN_RST);
      else if (wr_stb && wr_hit && wr_ofs == OFS_W'(g + 1))
        gain_flat[g*DATA_W +: DATA_W] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_ofs == '0) rd_data = ctrl_q;
    for (int g = 0; g < CH_COUNT; g++)
      if (rd_ofs == OFS_W'(g + 1)) rd_data = gain_flat[g*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/tw_out_decode.sv
module tw_out_decode
  import tw_ctrl_pkg::*;
#(
  parameter int DATA_W   = BYTE_W,
  parameter int CH_COUNT = NUM_CH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DATA_W-1:0]          ctrl_q,
  input  logic [CH_COUNT*DATA_W-1:0] gain_flat,
  output logic                       sleep,
  output logic [1:0]                 chan_sel,
  output logic [DATA_W-1:0]          gain_step
);
  chan_e             chan_d;
  logic [DATA_W-1:0] gain_d;

  assign chan_d = chan_of(ctrl_q[SEL_HI -: 2]);

  always_comb begin
    gain_d = '0;
    for (int g = 0; g < CH_COUNT; g++)
      if (int'(chan_d) == g) gain_d = gain_flat[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep     <= 1'b1;
      chan_sel  <= CH_A;
      gain_step <= gain_flat[DATA_W-1:0];
    end else begin
      sleep     <= (ctrl_q[PWR_HI -: 2] != 2'b11);
      chan_sel  <= chan_d;
      gain_step <= gain_d;
    end
  end
endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave
  import tw_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        strap,
  input  logic              frame_en,
  input  logic              ser_clk,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sleep,
  output logic [1:0]        chan_sel,
  output logic [BYTE_W-1:0] gain_step
);
  logic [BYTE_W-2:0]        addr_cand, wr_addr;
  logic                     rd_hit, wr_stb, edge_pulse;
  logic [BYTE_W-1:0]        rd_data, wr_data, ctrl_q;
  logic [NUM_CH*BYTE_W-1:0] gain_flat;

  tw_frame_rx #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(BYTE_W)) frame_i (
    .clk(clk), .rst(rst), .frame_en(frame_en), .ser_clk(ser_clk),
    .sdio_in(sdio_in), .rd_hit(rd_hit), .rd_data(rd_data),
    .addr_cand(addr_cand), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .edge_pulse(edge_pulse), .sdio_out(sdio_out),
    .sdio_oe(sdio_oe)
  );

  tw_regfile #(.DATA_W(BYTE_W), .CH_COUNT(NUM_CH)) regs_i (
    .clk(clk), .rst(rst), .strap(strap), .rd_addr(addr_cand),
    .rd_hit(rd_hit), .rd_data(rd_data), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .gain_flat(gain_flat)
  );

  tw_out_decode #(.DATA_W(BYTE_W), .CH_COUNT(NUM_CH)) dec_i (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .gain_flat(gain_flat),
    .sleep(sleep), .chan_sel(chan_sel), .gain_step(gain_step)
  );
endmodule

// File: rtl/tw_ctrl_slave_chk.sv
module tw_ctrl_slave_chk (
  input logic        clk,
  input logic        rst,
  input logic        frame_en,
  input logic        sdio_oe,
  input logic        sdio_out,
  input logic        sleep,
  input logic [1:0]  chan_sel,
  input logic        edge_pulse,
  input logic        wr_stb,
  input logic [3:0]  wr_ofs,
  input logic [7:0]  ctrl_q,
  input logic [23:0] gain_flat
);
  AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R1

  AST_EMPTY_OFS_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_ofs >= 4'd4) |=> ($stable(ctrl_q) && $stable(gain_flat))); // R5

  AST_OE_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    sdio_oe |-> $past(frame_en)); // R8

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sdio_oe && $past(sdio_oe) && !$past(edge_pulse)) |-> $stable(sdio_out)); // R7

  AST_SLEEP_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sleep == ($past(ctrl_q[7:6]) != 2'b11))); // R10

  AST_CHAN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    chan_sel != 2'b11); // R10
endmodule

bind tw_ctrl_slave tw_ctrl_slave_chk chk_i (
  .clk(clk), .rst(rst), .frame_en(frame_en), .sdio_oe(sdio_oe),
  .sdio_out(sdio_out), .sleep(sleep), .chan_sel(chan_sel),
  .edge_pulse(edge_pulse), .wr_stb(wr_stb), .wr_ofs(wr_addr[3:0]),
  .ctrl_q(ctrl_q), .gain_flat(gain_flat)
);

// File: tb/tw_ctrl_slave_tb_top.sv
module tw_ctrl_slave_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF       = 6;

  logic       clk = 1'b0, rst = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       frame_en = 1'b0, ser_clk = 1'b0, sdio_in = 1'b0;
  logic       sdio_out, sdio_oe, sleep;
  logic [1:0] chan_sel;
  logic [7:0] gain_step;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_ctrl;
  logic [7:0] m_gain [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_ctrl_slave dut_i (
    .clk(clk), .rst(rst), .strap(strap), .frame_en(frame_en),
    .ser_clk(ser_clk), .sdio_in(sdio_in), .sdio_out(sdio_out),
    .sdio_oe(sdio_oe), .sleep(sleep), .chan_sel(chan_sel),
    .gain_step(gain_step)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs one frame of n_edges serial clock rising edges.
  task automatic frame(input logic [7:0] addr, input logic [7:0] data, input int n_edges,
                       input bit drop_check, output logic [7:0] rd_val,
                       output bit oe_early, output bit oe_data_all, output bit oe_late);
    logic [15:0] bits;
    bits = {addr, data};
    rd_val = '0; oe_early = 0; oe_data_all = 1; oe_late = 0;
    @(negedge clk);
    frame_en = 1'b1;
    clocks(HALF);
    for (int i = 0; i < n_edges; i++) begin
      sdio_in = (i < 8 || !addr[7]) ? bits[15-i] : 1'b0;
      clocks(HALF);
      if (i < 8) oe_early |= sdio_oe;
      else begin
        rd_val[15-i] = sdio_out;
        oe_data_all &= sdio_oe;
      end
      ser_clk = 1'b1;
      clocks(HALF);
      ser_clk = 1'b0;
    end
    clocks(HALF);
    oe_late = sdio_oe;
    if (drop_check) chk("R8 oe before drop", {31'd0, sdio_oe}, 32'd1);
    frame_en = 1'b0;
    #1;
    if (drop_check) chk("R8 oe at enable drop", {31'd0, sdio_oe}, 32'd0);
    clocks(10);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    logic [7:0] v; bit a, b, c;
    frame({1'b0, addr[6:0]}, data, 16, 0, v, a, b, c);
  endtask

  function automatic logic [7:0] expect_ofs(input int k);
    if (k == 0) return m_ctrl;
    if (k >= 1 && k <= 3) return m_gain[k-1];
    return 8'h00;
  endfunction

  function automatic logic [2:0] win_of(input logic [1:0] s);
    return (s == 2'b00) ? 3'h0 : (s == 2'b01) ? 3'h1 : 3'h7;
  endfunction

  task automatic rd_hit_chk(input logic [7:0] addr, input logic [7:0] exp, input string req);
    logic [7:0] v; bit a, b, c;
    frame({1'b1, addr[6:0]}, 8'h00, 16, 0, v, a, b, c);
    chk(req, {24'd0, v}, {24'd0, exp});
    chk("R7 oe low in address phase", {31'd0, a}, 32'd0);
    chk("R7 oe high in data phase", {31'd0, b}, 32'd1);
    chk("R7 oe released after 16th edge", {31'd0, c}, 32'd0);
  endtask

  task automatic rd_miss_chk(input logic [7:0] addr);
    logic [7:0] v; bit a, b, c;
    frame({1'b1, addr[6:0]}, 8'h00, 16, 0, v, a, b, c);
    chk("R6 no drive outside window", {29'd0, a, b, c}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v; bit a, b, c;
    m_ctrl = 8'h00;
    for (int g = 0; g < 3; g++) m_gain[g] = 8'hFF;
    clocks(5);
    rst = 1'b0;
    clocks(3);
    chk("R10 reset sleep", {31'd0, sleep}, 32'd1);
    chk("R10 reset chan", {30'd0, chan_sel}, 32'd0);
    chk("R10 reset gain", {24'd0, gain_step}, 32'hFF);
    chk("R8 reset oe", {31'd0, sdio_oe}, 32'd0);
    rd_hit_chk(8'h00, 8'h00, "R3 ctrl reset value");
    for (int k = 1; k <= 3; k++) rd_hit_chk(8'(k), 8'hFF, "R4 gain reset value");

    // R2 R3 R4 R5 window sweep for each strap code
    for (int s = 0; s < 3; s++) begin
      strap = 2'(s);
      for (int k = 0; k < 16; k++) begin
        logic [7:0] val;
        val = 8'((s * 37 + k * 11 + 5) ^ (k << 4));
        wr({1'b0, win_of(strap), 4'(k)}, val);
        if (k == 0) m_ctrl = val;
        else if (k <= 3) m_gain[k-1] = val;
      end
      for (int k = 0; k < 16; k++)
        rd_hit_chk({1'b0, win_of(strap), 4'(k)}, expect_ofs(k),
                   k == 0 ? "R3 ctrl readback" : (k <= 3 ? "R4 gain readback" : "R5 empty offset reads zero"));
      for (int o = 0; o < 3; o++) begin
        if (o == s) continue;
        for (int k = 0; k < 16; k++) rd_miss_chk({1'b0, win_of(2'(o)), 4'(k)});
        wr({1'b0, win_of(2'(o)), 4'd2}, 8'h5A);
        rd_hit_chk({1'b0, win_of(strap), 4'd2}, m_gain[1], "R6 foreign write ignored");
      end
    end
    strap = 2'b11;
    clocks(4);
    rd_hit_chk(8'h71, m_gain[0], "R2 strap 11 maps to open window");
    rd_miss_chk(8'h01);

    // R1 edges past the 16th are ignored
    strap = 2'b00;
    clocks(4);
    frame(8'h03, 8'hC3, 20, 0, v, a, b, c);
    m_gain[2] = 8'hC3;
    rd_hit_chk(8'h03, 8'hC3, "R1 extra edges ignored");

    // R9 short write frame
    frame(8'h02, 8'h11, 12, 0, v, a, b, c);
    rd_hit_chk(8'h02, m_gain[1], "R9 short write has no effect");
    frame(8'h02, 8'h11, 15, 0, v, a, b, c);
    rd_hit_chk(8'h02, m_gain[1], "R9 15-edge write has no effect");

    // R8 aborted read: enable drop releases pin at once
    frame(8'h81, 8'h00, 12, 1, v, a, b, c);

    // R10 output decode sweep
    wr(8'h01, 8'h21); m_gain[0] = 8'h21;
    wr(8'h02, 8'h42); m_gain[1] = 8'h42;
    wr(8'h03, 8'h84); m_gain[2] = 8'h84;
    for (int n = 0; n < 16; n++) begin
      int ch;
      wr(8'h00, {4'(n), 4'h9});
      ch = (n[1:0] == 2'b11) ? 2 : (n[1:0] == 2'b10) ? 1 : 0;
      chk("R10 sleep decode", {31'd0, sleep}, {31'd0, (n[3:2] != 2'b11)});
      chk("R10 channel decode", {30'd0, chan_sel}, 32'(ch));
      chk("R10 gain of selected channel", {24'd0, gain_step}, {24'd0, m_gain[ch]});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule